// File: doc/BRIEF.md
# Decode-Stage Static Branch Predictor

This block sits between instruction fetch and the rest of decode. Every instruction word that enters it is classified as a relative branch that always jumps, a conditional relative branch, a branch whose destination comes from a register, or not a branch. For relative branches it also computes the destination address. It then chooses taken or not-taken by a fixed rule. The decoded branch kind, the destination and the prediction bit all travel downstream with the word in a single output register. A later execute stage compares the prediction bit with the real outcome and corrects the front end only when the prediction was wrong.

When the block predicts taken, it sends a one-cycle flush-and-redirect pulse toward fetch carrying the computed destination. The next word presented after such a branch is a wrong-path fetch, so the block discards it. A correction redirect from execute takes priority over everything else. It empties the output register, discards the word arriving in the same cycle, and is passed on to fetch as the upstream redirect in the following cycle.

Both data sides use valid/ready handshakes. A transfer happens on a clock edge where valid and ready are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle (`out_ready` high). While `out_valid` is high and `out_ready` is low, every output field holds its value. Once `out_valid` is raised it stays high until the word is taken or flushed.

Top module: `bp_static_decode`

## Requirements
- R1: After reset, `out_valid` and `redir_valid` are both low.
- R2: A word with opcode field bits [31:26] = 18 has kind 1 (relative, always jumps) and is predicted taken. Its byte offset is bits [25:2] shifted left by 2 and sign-extended, and its destination is `in_pc` plus that offset.
- R3: A word with opcode 16 has kind 2 (conditional relative). Its offset is bits [15:2] shifted left by 2 and sign-extended. It is predicted taken exactly when that offset is negative (bit 15 set).
- R4: A word with opcode 19 and bits [10:1] equal to 16 or 528 has kind 3 (destination from a register). It is never predicted taken by this block, raises no redirect, and reports destination 0.
- R5: When an accepted word is predicted taken by this block, `redir_valid` is high for exactly one cycle, starting the cycle after acceptance, with `redir_target` equal to the computed destination.
- R6: If `in_pred_taken` is high on an accepted word, then `out_pred_taken` is high and no redirect is raised for that word.
- R7: A word accepted while `redir_valid` is high is discarded and never appears at the output.
- R8: While `out_valid` is high and `out_ready` is low, `in_ready` is low, all output fields hold their values, and no further redirect is issued for the held branch.
- R9: A high `ex_redir_valid` at a clock edge clears `out_valid`, discards the word accepted at that edge, and raises `redir_valid` in the next cycle with `redir_target` equal to `ex_redir_target`.
- R10: Bit 1 of a kind 1 or kind 2 word selects absolute addressing: the destination is the sign-extended offset itself and `in_pc` is ignored.
- R11: Any other word has kind 0, destination 0, and `out_pred_taken` equal to `in_pred_taken`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Incoming word is valid |
| in_ready | output | 1 | Block can take a word this cycle |
| in_insn | input | 32 | Instruction word |
| in_pc | input | AW | Address of the instruction word |
| in_pred_taken | input | 1 | Word already predicted taken by a fetch-stage predictor |
| out_valid | output | 1 | Output register holds a word |
| out_ready | input | 1 | Downstream takes the word this cycle |
| out_insn | output | 32 | Instruction word passed downstream |
| out_pc | output | AW | Its address |
| out_kind | output | 2 | Branch kind: 0 none, 1 relative, 2 conditional relative, 3 register destination |
| out_target | output | AW | Computed destination (0 for kinds 0 and 3) |
| out_pred_taken | output | 1 | Prediction attached to the word |
| ex_redir_valid | input | 1 | Mispredict correction from execute |
| ex_redir_target | input | AW | Corrected fetch address |
| redir_valid | output | 1 | Flush and redirect toward fetch |
| redir_target | output | AW | Redirect address |

## Verification
The assertions assume that reset is held for at least one edge and that `out_ready`, `in_valid` and `ex_redir_valid` are ordinary synchronous levels with no other side effects. They also assume that `out_ready` may drop at any time and that downstream never needs a held word to change. The stimulus toggles these inputs freely but only away from the clock edge. It runs one phase per instruction class, plus phases that stall downstream at random and inject execute corrections at random. That lets the held-output, redirect-pulse and discard rules each meet every kind of word.

// File: rtl/bp_pkg.sv
package bp_pkg;
  typedef enum logic [1:0] {
    BK_NONE = 2'd0,
    BK_REL  = 2'd1,
    BK_COND = 2'd2,
    BK_REG  = 2'd3
  } br_kind_e;

  localparam int OFF_W = 26;
endpackage

// File: rtl/bp_classify.sv
module bp_classify
  import bp_pkg::*;
#(
  parameter logic [5:0] OPC_REL  = 6'd18,
  parameter logic [5:0] OPC_COND = 6'd16,
  parameter logic [5:0] OPC_REGX = 6'd19,
  parameter logic [9:0] XO_LINK  = 10'd16,
  parameter logic [9:0] XO_COUNT = 10'd528
) (
  input  logic [31:0]      insn,
  output br_kind_e         kind,
  output logic [OFF_W-1:0] offset,
  output logic             is_abs,
  output logic             static_taken
);
  logic [5:0] opc;
  logic [9:0] xo;

  assign opc = insn[31:26];
  assign xo  = insn[10:1];

  always_comb begin
    kind         = BK_NONE;
    offset       = '0;
    static_taken = 1'b0;
    if (opc == OPC_REL) begin
      kind         = BK_REL;
      offset       = {insn[25:2], 2'b00};
      static_taken = 1'b1;
    end else if (opc == OPC_COND) begin
      kind         = BK_COND;
      offset       = {{(OFF_W-16){insn[15]}}, insn[15:2], 2'b00};
      static_taken = insn[15];
    end else if (opc == OPC_REGX && (xo == XO_LINK || xo == XO_COUNT)) begin
      kind = BK_REG;
    end
  end

  assign is_abs = insn[1];
endmodule

// File: rtl/bp_target.sv
module bp_target
  import bp_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [AW-1:0]    pc,
  input  br_kind_e         kind,
  input  logic [OFF_W-1:0] offset,
  input  logic             is_abs,
  output logic [AW-1:0]    target
);
  logic [AW-1:0] off_ext;

  generate
    if (AW > OFF_W) begin : g_wide
      assign off_ext = {{(AW-OFF_W){offset[OFF_W-1]}}, offset};
    end else begin : g_narrow
      assign off_ext = offset[AW-1:0];
    end
  endgenerate

  always_comb begin
    if (kind == BK_REL || kind == BK_COND)
      target = is_abs ? off_ext : pc + off_ext;
    else
      target = '0;
  end
endmodule

// File: rtl/bp_static_decode.sv
module bp_static_decode
  import bp_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [31:0]   in_insn,
  input  logic [AW-1:0] in_pc,
  input  logic          in_pred_taken,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [31:0]   out_insn,
  output logic [AW-1:0] out_pc,
  output logic [1:0]    out_kind,
  output logic [AW-1:0] out_target,
  output logic          out_pred_taken,
  input  logic          ex_redir_valid,
  input  logic [AW-1:0] ex_redir_target,
  output logic          redir_valid,
  output logic [AW-1:0] redir_target
);
  br_kind_e         c_kind;
  logic [OFF_W-1:0] c_off;
  logic             c_abs;
  logic             c_taken;
  logic [AW-1:0]    c_target;
  logic             slot_free;
  logic             accept;
  logic             raise;

  bp_classify u_cls (
    .insn         (in_insn),
    .kind         (c_kind),
    .offset       (c_off),
    .is_abs       (c_abs),
    .static_taken (c_taken)
  );

  bp_target #(.AW(AW)) u_tgt (
    .pc     (in_pc),
    .kind   (c_kind),
    .offset (c_off),
    .is_abs (c_abs),
    .target (c_target)
  );

  assign slot_free = out_ready || !out_valid;
  assign in_ready  = slot_free;
  assign accept    = in_valid && slot_free && !redir_valid && !ex_redir_valid;
  assign raise     = accept && c_taken && !in_pred_taken;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid      <= 1'b0;
      out_insn       <= '0;
      out_pc         <= '0;
      out_kind       <= '0;
      out_target     <= '0;
      out_pred_taken <= 1'b0;
      redir_valid    <= 1'b0;
      redir_target   <= '0;
    end else if (ex_redir_valid) begin
      out_valid    <= 1'b0;
      redir_valid  <= 1'b1;
      redir_target <= ex_redir_target;
    end else begin
      if (slot_free) begin
        out_valid <= accept;
        if (accept) begin
          out_insn       <= in_insn;
          out_pc         <= in_pc;
          out_kind       <= c_kind;
          out_target     <= c_target;
          out_pred_taken <= in_pred_taken | c_taken;
        end
      end
      redir_valid <= raise;
      if (raise) redir_target <= c_target;
    end
  end

  AST_REDIR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (redir_valid && !ex_redir_valid) |=> !redir_valid); // R5

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !ex_redir_valid) |=>
      (out_valid && $stable(out_insn) && $stable(out_pc) && $stable(out_target))); // R8

  AST_EX_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    ex_redir_valid |=> (redir_valid && !out_valid &&
      redir_target == $past(ex_redir_target))); // R9

  AST_WRONG_PATH_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (redir_valid && (out_ready || !out_valid)) |=> !out_valid); // R7
endmodule

// File: tb/bp_static_decode_tb.sv
module bp_static_decode_tb;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid;
  logic          in_ready;
  logic [31:0]   in_insn;
  logic [AW-1:0] in_pc;
  logic          in_pred_taken;
  logic          out_valid;
  logic          out_ready;
  logic [31:0]   out_insn;
  logic [AW-1:0] out_pc;
  logic [1:0]    out_kind;
  logic [AW-1:0] out_target;
  logic          out_pred_taken;
  logic          ex_redir_valid;
  logic [AW-1:0] ex_redir_target;
  logic          redir_valid;
  logic [AW-1:0] redir_target;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  bp_static_decode #(.AW(AW)) u_dut (.*);

  // reference state
  bit          m_ov, m_rv, m_pt;
  logic [31:0] m_insn, m_pc, m_tgt, m_rt;
  int          m_kind;

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // behavioural expectation from the requirements
  task automatic predict(input logic [31:0] w, input logic [31:0] pc, input bit pre,
                         output int kind, output logic [31:0] tgt, output bit st);
    int unsigned opc = w[31:26];
    int unsigned xo  = w[10:1];
    int off;
    kind = 0; tgt = 0; st = 0;
    if (opc == 18) begin
      kind = 1;
      off = int'({{6{w[25]}}, w[25:2], 2'b00});
      st = 1;
    end else if (opc == 16) begin
      kind = 2;
      off = int'({{16{w[15]}}, w[15:2], 2'b00});
      st = (off < 0);
    end else if (opc == 19 && (xo == 16 || xo == 528)) begin
      kind = 3;
    end
    if (kind == 1 || kind == 2) tgt = w[1] ? 32'(off) : pc + 32'(off);
    if (pre) st = st; // pre-marked words keep their flag; redirect handled by caller
  endtask

  function automatic logic [31:0] gen(int mode, bit absb);
    logic [31:0] w = $urandom;
    int m = mode;
    if (m == 4) m = $urandom_range(0, 3);
    case (m)
      0: w[31:26] = 6'd18;
      1: w[31:26] = 6'd16;
      2: begin w[31:26] = 6'd19; w[10:1] = ($urandom_range(0,1) != 0) ? 10'd16 : 10'd528; end
      default: begin
        w[31:26] = 6'($urandom_range(20, 63));
      end
    endcase
    w[1] = absb;
    return w;
  endfunction

  task automatic run_phase(string tag, int mode, bit absb, bit pre, int rdy_pct, int ex_pct, int n);
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      // compare state produced by the last edge
      chk(tag, "out_valid", out_valid, m_ov);
      chk(tag, "redir_valid", redir_valid, m_rv);
      if (m_rv) chk(tag, "redir_target", redir_target, m_rt);
      if (m_ov) begin
        chk(tag, "out_insn", out_insn, m_insn);
        chk(tag, "out_pc", out_pc, m_pc);
        chk(tag, "out_kind", out_kind, m_kind[1:0]);
        chk(tag, "out_target", out_target, m_tgt);
        chk(tag, "out_pred_taken", out_pred_taken, m_pt);
      end
      // new stimulus
      in_valid        = ($urandom_range(0, 99) < 85);
      in_insn         = gen(mode, absb);
      in_pc           = {$urandom_range(0, 32'h3fffffff), 2'b00};
      in_pred_taken   = pre;
      out_ready       = ($urandom_range(0, 99) < rdy_pct);
      ex_redir_valid  = ($urandom_range(0, 99) < ex_pct);
      ex_redir_target = $urandom;
      #1;
      begin
        bit slot = out_ready || !m_ov;
        int k; logic [31:0] t; bit st;
        chk(tag, "in_ready", in_ready, slot);
        predict(in_insn, in_pc, in_pred_taken, k, t, st);
        if (ex_redir_valid) begin
          m_ov = 0; m_rv = 1; m_rt = ex_redir_target;
        end else begin
          bit take = in_valid && slot && !m_rv;
          if (slot) begin
            m_ov = take;
            if (take) begin
              m_insn = in_insn; m_pc = in_pc; m_kind = k; m_tgt = t;
              m_pt = in_pred_taken | st;
            end
          end
          m_rv = take && st && !in_pred_taken;
          if (m_rv) m_rt = t;
        end
      end
    end
  endtask

  initial begin
    rst_n = 0; in_valid = 0; in_insn = 0; in_pc = 0; in_pred_taken = 0;
    out_ready = 1; ex_redir_valid = 0; ex_redir_target = 0;
    m_ov = 0; m_rv = 0; m_pt = 0; m_insn = 0; m_pc = 0; m_tgt = 0; m_rt = 0; m_kind = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "out_valid", out_valid, 0);
    chk("R1", "redir_valid", redir_valid, 0);
    rst_n = 1;
    run_phase("R2",  0, 0, 0, 100, 0, 300);
    run_phase("R3",  1, 0, 0, 100, 0, 300);
    run_phase("R4",  2, 0, 0, 100, 0, 300);
    run_phase("R5",  4, 0, 0, 100, 0, 300);
    run_phase("R6",  4, 0, 1, 80,  0, 300);
    run_phase("R7",  0, 0, 0, 90,  0, 300);
    run_phase("R8",  4, 0, 0, 40,  0, 400);
    run_phase("R9",  4, 0, 0, 70,  12, 400);
    run_phase("R10", 4, 1, 0, 80,  0, 300);
    run_phase("R11", 3, 0, 0, 80,  0, 300);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule